// File: doc/BRIEF.md
# Viewport-Indexed Outbound Address Translator

This block rewrites outgoing request addresses for a host bridge. It holds four outbound regions. Each region has a 64-bit base, an inclusive 32-bit limit, a 64-bit target and a transaction-kind code. Every cycle, a 64-bit request address is compared against all enabled regions at once. On a hit, the response carries the translated bus address, which is the target plus the offset into the region, together with the region's kind code: memory, I/O, type-0 configuration or type-1 configuration. On a miss, a no-match flag is raised instead.

Software does not see a flat register map. It first writes a viewport register that names one region and a direction. All further accesses to the window of per-region registers then go to that one region. For configuration regions, software places the bus number in bits 31:24 of the lower target word, the device in bits 23:19 and the function in bits 18:16. Because the offset into the region is added to the target, the configuration-space offset lands in the low bits.

Top module: `vpx_outbound_xlate`

## Requirements
- R1: After reset, every region is disabled and the viewport reads 0x0000_0000. Every request made before any programming misses.
- R2: The viewport lives at byte offset 0x900. Bit 31 is the direction: 1 is inbound, 0 is outbound. Bits 2:0 hold the region index. Readback returns only these bits; every other bit reads zero.
- R3: The window offsets act on the selected region as follows. 0x904 holds the kind code in bits 2:0. 0x908 holds the enable in bit 31. 0x90C holds the base low word and 0x910 the base high word. 0x914 holds the limit. 0x918 holds the target low word and 0x91C the target high word. Readback returns the stored value, and unused bits of 0x904 and 0x908 read zero.
- R4: When the viewport selects inbound, or an index of 4 or more, window writes change no region and window reads return zero.
- R5: Any offset outside 0x900 to 0x91C reads zero, and a write to it changes nothing.
- R6: A request hits a region only when all of these hold: the region is enabled, the request's upper 32 bits equal the base high word, and base low word ≤ request low word ≤ limit. Both ends of the range are inclusive.
- R7: On a hit, the response address is {target high, target low} + (request − {base high, base low}), taken modulo 2^64. The response kind is the region's code: 0 memory, 2 I/O, 4 type-0 configuration, 5 type-1 configuration.
- R8: When more than one region hits, the region with the lowest index decides the response.
- R9: On a miss, rsp_miss is 1, rsp_hit is 0, and rsp_type and rsp_addr are zero.
- R10: A response appears exactly one cycle after each request. A window write made in the same cycle as a request affects only the requests made in later cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register readback for cfg_addr (combinational) |
| req_valid | input | 1 | Translation request present |
| req_addr | input | 64 | Request address |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_hit | output | 1 | Request matched a region |
| rsp_miss | output | 1 | Request matched no region |
| rsp_addr | output | 64 | Translated address |
| rsp_type | output | 3 | Transaction kind code of the hit region |

## Verification
A register write and a translation can fall in the same cycle. The bench provokes this by issuing a request to a live region while, in that same cycle, it clears that region's enable through the window. It then issues the same request again one cycle later. The bench's behavioural model computes each expected response before it applies that cycle's write. The first response must therefore still hit and the second must miss, and the every-cycle comparison judges both.

// File: rtl/vpx_pkg.sv
package vpx_pkg;

    localparam int WORD_W = 32;

    localparam logic [11:0] OFF_VIEW  = 12'h900;
    localparam logic [11:0] OFF_KIND  = 12'h904;
    localparam logic [11:0] OFF_CTRL  = 12'h908;
    localparam logic [11:0] OFF_BASEL = 12'h90C;
    localparam logic [11:0] OFF_BASEH = 12'h910;
    localparam logic [11:0] OFF_LIMIT = 12'h914;
    localparam logic [11:0] OFF_TGTL  = 12'h918;
    localparam logic [11:0] OFF_TGTH  = 12'h91C;

    typedef enum logic [2:0] {
        FLD_NONE,
        FLD_KIND,
        FLD_CTRL,
        FLD_BASEL,
        FLD_BASEH,
        FLD_LIMIT,
        FLD_TGTL,
        FLD_TGTH
    } vpx_field_e;

    typedef struct packed {
        logic              en;
        logic [2:0]        kind;
        logic [WORD_W-1:0] base_lo;
        logic [WORD_W-1:0] base_hi;
        logic [WORD_W-1:0] limit;
        logic [WORD_W-1:0] tgt_lo;
        logic [WORD_W-1:0] tgt_hi;
    } vpx_rgn_t;

endpackage

// File: rtl/vpx_region_regs.sv
module vpx_region_regs
    import vpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  vpx_field_e        field,
    input  logic [WORD_W-1:0] wdata,
    output vpx_rgn_t          rgn_q
);

    vpx_rgn_t rgn_d;

    always_comb begin
        rgn_d = rgn_q;
        if (wr_en) begin
            case (field)
                FLD_KIND:  rgn_d.kind    = wdata[2:0];
                FLD_CTRL:  rgn_d.en      = wdata[WORD_W-1];
                FLD_BASEL: rgn_d.base_lo = wdata;
                FLD_BASEH: rgn_d.base_hi = wdata;
                FLD_LIMIT: rgn_d.limit   = wdata;
                FLD_TGTL:  rgn_d.tgt_lo  = wdata;
                FLD_TGTH:  rgn_d.tgt_hi  = wdata;
                default:   rgn_d = rgn_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rgn_q <= '0;
        else        rgn_q <= rgn_d;
    end

    // R4
    untouched_rgn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rgn_q));

endmodule

// File: rtl/vpx_cfg_regs.sv
module vpx_cfg_regs
    import vpx_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    parameter int CFG_AW      = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    output vpx_rgn_t          rgn_o [NUM_REGIONS]
);

    localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
    localparam int VPW   = IDX_W + 1;

    typedef struct packed {
        logic           dir;
        logic [VPW-1:0] idx;
    } view_t;

    view_t      view_d, view_q;
    vpx_field_e field;
    logic       view_hit;
    logic       sel_ok;
    vpx_rgn_t   cur;

    always_comb begin
        field    = FLD_NONE;
        view_hit = 1'b0;
        case (cfg_addr)
            OFF_VIEW:  view_hit = 1'b1;
            OFF_KIND:  field = FLD_KIND;
            OFF_CTRL:  field = FLD_CTRL;
            OFF_BASEL: field = FLD_BASEL;
            OFF_BASEH: field = FLD_BASEH;
            OFF_LIMIT: field = FLD_LIMIT;
            OFF_TGTL:  field = FLD_TGTL;
            OFF_TGTH:  field = FLD_TGTH;
            default:   field = FLD_NONE;
        endcase
    end

    assign sel_ok = !view_q.dir && (view_q.idx < VPW'(NUM_REGIONS));

    always_comb begin
        view_d = view_q;
        if (cfg_wr && view_hit) begin
            view_d.dir = cfg_wdata[WORD_W-1];
            view_d.idx = cfg_wdata[VPW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) view_q <= '0;
        else        view_q <= view_d;
    end

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
        vpx_region_regs u_regs (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (cfg_wr && sel_ok && (view_q.idx == VPW'(g))),
            .field (field),
            .wdata (cfg_wdata),
            .rgn_q (rgn_o[g])
        );
    end

    assign cur = rgn_o[view_q.idx[IDX_W-1:0]];

    always_comb begin
        cfg_rdata = '0;
        if (view_hit) begin
            cfg_rdata[VPW-1:0]  = view_q.idx;
            cfg_rdata[WORD_W-1] = view_q.dir;
        end else if (sel_ok) begin
            case (field)
                FLD_KIND:  cfg_rdata[2:0]      = cur.kind;
                FLD_CTRL:  cfg_rdata[WORD_W-1] = cur.en;
                FLD_BASEL: cfg_rdata = cur.base_lo;
                FLD_BASEH: cfg_rdata = cur.base_hi;
                FLD_LIMIT: cfg_rdata = cur.limit;
                FLD_TGTL:  cfg_rdata = cur.tgt_lo;
                FLD_TGTH:  cfg_rdata = cur.tgt_hi;
                default:   cfg_rdata = '0;
            endcase
        end
    end

    // R2
    view_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == OFF_VIEW) |=>
            (view_q.idx == $past(cfg_wdata[VPW-1:0]) && view_q.dir == $past(cfg_wdata[WORD_W-1])));

    // R5
    view_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr != OFF_VIEW) |=> $stable(view_q));

endmodule

// File: rtl/vpx_region_match.sv
module vpx_region_match
    import vpx_pkg::*;
(
    input  vpx_rgn_t    rgn,
    input  logic [63:0] req_addr,
    output logic        hit,
    output logic [63:0] xaddr
);

    logic [63:0] base;
    logic [63:0] tgt;

    assign base  = {rgn.base_hi, rgn.base_lo};
    assign tgt   = {rgn.tgt_hi, rgn.tgt_lo};
    assign hit   = rgn.en
                && (req_addr[63:32] == rgn.base_hi)
                && (req_addr[31:0] >= rgn.base_lo)
                && (req_addr[31:0] <= rgn.limit);
    assign xaddr = tgt + (req_addr - base);

endmodule

// File: rtl/vpx_prio_pick.sv
module vpx_prio_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] hits,
    output logic [N-1:0] grant,
    output logic         any,
    output logic [((N > 1) ? $clog2(N) : 1)-1:0] idx
);

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = IDX_W'(i);
            end
        end
    end

    assign any = |hits;

endmodule

// File: rtl/vpx_outbound_xlate.sv
module vpx_outbound_xlate
    import vpx_pkg::*;
#(
    parameter int NUM_REGIONS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [11:0] cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        req_valid,
    input  logic [63:0] req_addr,
    output logic        rsp_valid,
    output logic        rsp_hit,
    output logic        rsp_miss,
    output logic [63:0] rsp_addr,
    output logic [2:0]  rsp_type
);

    localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

    typedef struct packed {
        logic        valid;
        logic        hit;
        logic        miss;
        logic [63:0] addr;
        logic [2:0]  kind;
    } rsp_t;

    vpx_rgn_t                rgns  [NUM_REGIONS];
    logic [63:0]             xaddr [NUM_REGIONS];
    logic [NUM_REGIONS-1:0]  hits;
    logic [NUM_REGIONS-1:0]  grant;
    logic [NUM_REGIONS-1:0]  en_vec;
    logic                    any_hit;
    logic [IDX_W-1:0]        win;
    rsp_t                    rsp_d, rsp_q;

    vpx_cfg_regs #(
        .NUM_REGIONS (NUM_REGIONS),
        .CFG_AW      (12)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .rgn_o     (rgns)
    );

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
        vpx_region_match u_match (
            .rgn      (rgns[g]),
            .req_addr (req_addr),
            .hit      (hits[g]),
            .xaddr    (xaddr[g])
        );
        assign en_vec[g] = rgns[g].en;
    end

    vpx_prio_pick #(.N(NUM_REGIONS)) u_pick (
        .hits  (hits),
        .grant (grant),
        .any   (any_hit),
        .idx   (win)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            if (any_hit) begin
                rsp_d.hit  = 1'b1;
                rsp_d.addr = xaddr[win];
                rsp_d.kind = rgns[win].kind;
            end else begin
                rsp_d.miss = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_miss  = rsp_q.miss;
    assign rsp_addr  = rsp_q.addr;
    assign rsp_type  = rsp_q.kind;

    // R8
    single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R9
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_miss) |-> (rsp_type == 3'd0 && rsp_addr == 64'd0 && !rsp_hit));

    // R10
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R6
    hit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && en_vec == '0) |=> !rsp_hit);

endmodule

// File: tb/tb_vpx_outbound_xlate.sv
module tb_vpx_outbound_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_miss;
    logic [63:0] rsp_addr;
    logic [2:0]  rsp_type;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    vpx_outbound_xlate dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_addr(rsp_addr), .rsp_type(rsp_type)
    );

    // behavioural model state
    logic        m_en  [4];
    logic [2:0]  m_ty  [4];
    logic [31:0] m_lb [4], m_ub [4], m_lim [4], m_lt [4], m_ut [4];
    logic        m_dir;
    logic [2:0]  m_idx;
    logic        e_valid, e_hit;
    logic [63:0] e_addr;
    logic [2:0]  e_type;

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        int k;
        k = int'(m_idx);
        if (a == 12'h900) begin
            m_dir = d[31];
            m_idx = d[2:0];
        end else if (!m_dir && k < 4) begin
            case (a)
                12'h904: m_ty[k]  = d[2:0];
                12'h908: m_en[k]  = d[31];
                12'h90C: m_lb[k]  = d;
                12'h910: m_ub[k]  = d;
                12'h914: m_lim[k] = d;
                12'h918: m_lt[k]  = d;
                12'h91C: m_ut[k]  = d;
                default: ;
            endcase
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_en[i] = 0; m_ty[i] = 0; m_lb[i] = 0; m_ub[i] = 0;
                m_lim[i] = 0; m_lt[i] = 0; m_ut[i] = 0;
            end
            m_dir = 0; m_idx = 0;
            e_valid = 0; e_hit = 0; e_addr = 0; e_type = 0;
        end else begin
            e_valid = req_valid; e_hit = 0; e_addr = 0; e_type = 0;
            if (req_valid) begin
                for (int i = 0; i < 4; i++) begin
                    if (!e_hit && m_en[i] && req_addr[63:32] == m_ub[i] &&
                        req_addr[31:0] >= m_lb[i] && req_addr[31:0] <= m_lim[i]) begin
                        e_hit  = 1;
                        e_addr = {m_ut[i], m_lt[i]} + (req_addr - {m_ub[i], m_lb[i]});
                        e_type = m_ty[i];
                    end
                end
            end
            if (cfg_wr) model_write(cfg_addr, cfg_wdata);
        end
    end

    // every-cycle comparison against the model (R10 timing, R7/R9 content)
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (rsp_valid !== e_valid ||
                (e_valid && (rsp_hit !== e_hit || rsp_miss !== !e_hit ||
                             rsp_addr !== e_addr || rsp_type !== e_type))) begin
                fails++;
                $display("FAIL R10 model: act v=%0b h=%0b m=%0b a=%h t=%0d exp v=%0b h=%0b a=%h t=%0d",
                         rsp_valid, rsp_hit, rsp_miss, rsp_addr, rsp_type,
                         e_valid, e_hit, e_addr, e_type);
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_addr = a;
        #1;
        checks++;
        if (cfg_rdata !== exp) begin
            fails++;
            $display("FAIL %s read %h: act %h exp %h", tag, a, cfg_rdata, exp);
        end
    endtask

    task automatic xl(input logic [63:0] a, input logic eh, input logic [63:0] ea,
                      input logic [2:0] et, input string tag);
        @(negedge clk);
        req_valid = 1; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        checks++;
        if (rsp_valid !== 1 || rsp_hit !== eh || rsp_miss !== !eh ||
            rsp_addr !== ea || rsp_type !== et) begin
            fails++;
            $display("FAIL %s req %h: act h=%0b m=%0b a=%h t=%0d exp h=%0b a=%h t=%0d",
                     tag, a, rsp_hit, rsp_miss, rsp_addr, rsp_type, eh, ea, et);
        end
    endtask

    task automatic prog(input int i, input logic [31:0] lb, ub, lim, lt, ut,
                        input logic [2:0] ty, input logic en);
        wr(12'h900, 32'(i));
        wr(12'h90C, lb); wr(12'h910, ub); wr(12'h914, lim);
        wr(12'h918, lt); wr(12'h91C, ut); wr(12'h904, {29'd0, ty});
        wr(12'h908, {en, 31'd0});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(12'h900, 32'h0, "R1");
        rd(12'h908, 32'h0, "R1");
        xl(64'h0000_0000_0000_1000, 0, 0, 0, "R1");

        // R2 viewport field masking
        wr(12'h900, 32'h7FFF_FFF2);
        rd(12'h900, 32'h0000_0002, "R2");

        // region 0: type-0 config window, bus 1
        prog(0, 32'h4000_0000, 32'h0, 32'h4FFF_FFFF, 32'h0100_0000, 32'h0, 3'd4, 1);
        rd(12'h90C, 32'h4000_0000, "R3");
        rd(12'h914, 32'h4FFF_FFFF, "R3");
        rd(12'h918, 32'h0100_0000, "R3");
        wr(12'h904, 32'hFFFF_FFFC);
        rd(12'h904, 32'h0000_0004, "R3");
        wr(12'h908, 32'hFFFF_FFFF);
        rd(12'h908, 32'h8000_0000, "R3");
        xl(64'h0000_0000_4000_0010, 1, 64'h0100_0010, 3'd4, "R7");
        xl(64'h0000_0000_4FFF_FFFF, 1, 64'h10FF_FFFF, 3'd4, "R6");
        xl(64'h0000_0000_5000_0000, 0, 0, 0, "R6");
        xl(64'h0000_0000_3FFF_FFFF, 0, 0, 0, "R6");
        xl(64'h0000_0000_4000_0000, 1, 64'h0100_0000, 3'd4, "R6");

        // region 1 overlaps region 0: memory, target above 4 GiB
        prog(1, 32'h4800_0000, 32'h0, 32'h48FF_FFFF, 32'h8000_0000, 32'h1, 3'd0, 1);
        xl(64'h0000_0000_4800_0004, 1, 64'h0900_0004, 3'd4, "R8");
        wr(12'h900, 32'h0);
        wr(12'h908, 32'h0);
        xl(64'h0000_0000_4800_0004, 1, 64'h1_8000_0004, 3'd0, "R8");

        // region 2: I/O with nonzero upper base
        prog(2, 32'h0, 32'h12, 32'h0000_FFFF, 32'h0001_0000, 32'h0, 3'd2, 1);
        xl(64'h0000_0012_0000_0100, 1, 64'h0001_0100, 3'd2, "R7");
        xl(64'h0000_0013_0000_0100, 0, 0, 0, "R6");

        // region 3: type-1 config, bus 2 dev 1 fn 0
        prog(3, 32'h6000_0000, 32'h0, 32'h6000_0FFF, 32'h0208_0000, 32'h0, 3'd5, 1);
        xl(64'h0000_0000_6000_0ABC, 1, 64'h0208_0ABC, 3'd5, "R7");

        // R4 inbound direction and out-of-range index
        wr(12'h900, 32'h8000_0001);
        rd(12'h900, 32'h8000_0001, "R2");
        wr(12'h918, 32'hDEAD_BEEF);
        rd(12'h918, 32'h0, "R4");
        wr(12'h900, 32'h0000_0004);
        wr(12'h90C, 32'hDEAD_BEEF);
        rd(12'h90C, 32'h0, "R4");
        wr(12'h900, 32'h0000_0001);
        rd(12'h918, 32'h8000_0000, "R4");
        rd(12'h90C, 32'h4800_0000, "R4");

        // R5 unmapped offsets
        wr(12'h920, 32'hFFFF_FFFF);
        rd(12'h920, 32'h0, "R5");
        rd(12'h8FC, 32'h0, "R5");
        rd(12'h918, 32'h8000_0000, "R5");

        // R10 write and request in the same cycle
        wr(12'h900, 32'h3);
        @(negedge clk);
        cfg_wr = 1; cfg_addr = 12'h908; cfg_wdata = 32'h0;
        req_valid = 1; req_addr = 64'h0000_0000_6000_0000;
        @(negedge clk);
        cfg_wr = 0;
        checks++;
        if (rsp_hit !== 1 || rsp_addr !== 64'h0208_0000 || rsp_type !== 3'd5) begin
            fails++;
            $display("FAIL R10 same-cycle: act h=%0b a=%h t=%0d exp h=1 a=%h t=5",
                     rsp_hit, rsp_addr, rsp_type, 64'h0208_0000);
        end
        @(negedge clk);
        req_valid = 0;
        checks++;
        if (rsp_miss !== 1 || rsp_hit !== 0) begin
            fails++;
            $display("FAIL R10 after write: act h=%0b m=%0b exp h=0 m=1", rsp_hit, rsp_miss);
        end

        // R9 miss outputs
        xl(64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, "R9");

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule